// File: doc/BRIEF.md
# Configurable Interrupt Status Controller

This block gathers event lines from an audio interface into two status banks and merges them into one interrupt output. Each implemented source bit has its own trigger rule (rising edge, falling edge or level), chosen by a bit pair split across a "high" mode register and a "low" mode register. Each source also has an enable bit that decides whether it can raise the interrupt.

Edge-triggered bits are sticky and are cleared when software reads their bank. Level-triggered bits follow the live input. The combined request is the OR of all enabled status bits in both banks. It is then shaped for the board by a two-bit pin style: active high, active low, or open-drain active low. In open-drain style the block only pulls the line low or releases it.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every status bit, enable bit and mode bit is zero and the pin style is active high. So `irq_level` is 0 and `irq_drive` is 1.
- R2: The configuration registers read back what was written: pin style at address 0, bank A enable/high/low at 3/4/5, and bank B enable/high/low at 6/7/8. Read data appears on `reg_rdata` on the clock edge that samples `reg_rd`. Writes to the status addresses (1 for bank A, 2 for bank B) have no effect.
- R3: With mode pair {high,low} = 00, a 0-to-1 change on an event input sets its status bit at the next clock edge. The bit stays set while the input stays high.
- R4: With mode pair 01, only a 1-to-0 change sets the status bit. A 0-to-1 change does not set it.
- R5: With mode pair 10, and also with the reserved pair 11, the status bit copies the event input one clock later, and a read does not clear it.
- R6: Reading a bank returns its status before the read and clears that bank's edge-mode bits. An edge that lands on the same edge as the read leaves its bit set.
- R7: An enable bit of 0 keeps a status bit from raising the interrupt, but the bit is still recorded in status.
- R8: The internal request is the OR of the enabled status bits of both banks. A bank B bit alone raises it.
- R9: Pin style 00 drives `irq_level` equal to the request, with `irq_drive` held at 1. The reserved style 11 behaves the same way.
- R10: Pin style 01 drives `irq_level` as the inverse of the request, with `irq_drive` held at 1.
- R11: Pin style 10 holds `irq_level` at 0 and sets `irq_drive` to the request, so the line is released while no request is pending.
- R12: Bank A implements bits 7, 6, 2, 1 and 0. Bank B implements bits 3, 2 and 1. All other status bits read as 0 and are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears edge bits of a read bank) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ev_a | input | 8 | Live event conditions for bank A |
| ev_b | input | 8 | Live event conditions for bank B |
| irq_level | output | 1 | Value driven onto the interrupt line |
| irq_drive | output | 1 | Output enable of the interrupt line (0 = released) |

## Verification
The detectors are tried with isolated 0-to-1 and 1-to-0 changes under each mode pair. This separates rising from falling sensitivity, and sticky behaviour from level following, including the reserved pair. Wide patterns that toggle only unimplemented bits show that those positions stay silent. A read issued on the same edge as a new rising edge tells a clear-wins design from a set-wins design. A single pending source is then viewed through all four pin styles, with its enable toggled, and drawn from either bank. This tells the masking, the cross-bank OR and the polarity or drive shaping apart.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [DW-1:0] IMPL_A = 8'hC7;
    localparam logic [DW-1:0] IMPL_B = 8'h0E;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        PIN_HIGH = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_OD   = 2'b10,
        PIN_RSVD = 2'b11
    } pin_e;

    typedef enum logic [AW-1:0] {
        ADR_PINCFG = 4'd0,
        ADR_STAT_A = 4'd1,
        ADR_STAT_B = 4'd2,
        ADR_EN_A   = 4'd3,
        ADR_HI_A   = 4'd4,
        ADR_LO_A   = 4'd5,
        ADR_EN_B   = 4'd6,
        ADR_HI_B   = 4'd7,
        ADR_LO_B   = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } bank_cfg_t;

    typedef struct packed {
        logic level;
        logic drive;
    } pin_out_t;

    function automatic trig_e trig_of(input logic hi, input logic lo);
        return trig_e'({hi, lo});
    endfunction

    function automatic logic trig_is_level(input trig_e t);
        return (t == TRIG_LEVEL) || (t == TRIG_RSVD);
    endfunction

    function automatic pin_out_t shape_pin(input pin_e style, input logic req);
        pin_out_t p;
        unique case (style)
            PIN_LOW:  begin p.level = ~req; p.drive = 1'b1; end
            PIN_OD:   begin p.level = 1'b0; p.drive = req;  end
            default:  begin p.level = req;  p.drive = 1'b1; end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/isc_cfg_regs.sv
module isc_cfg_regs
    import isc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output bank_cfg_t           cfg_a,
    output bank_cfg_t           cfg_b,
    output pin_e                style
);
    bank_cfg_t cfg_a_q, cfg_b_q;
    pin_e      style_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a_q <= '0;
            cfg_b_q <= '0;
            style_q <= PIN_HIGH;
        end else if (wr) begin
            unique case (reg_addr_e'(addr))
                ADR_PINCFG: style_q    <= pin_e'(wdata[1:0]);
                ADR_EN_A:   cfg_a_q.en <= wdata;
                ADR_HI_A:   cfg_a_q.hi <= wdata;
                ADR_LO_A:   cfg_a_q.lo <= wdata;
                ADR_EN_B:   cfg_b_q.en <= wdata;
                ADR_HI_B:   cfg_b_q.hi <= wdata;
                ADR_LO_B:   cfg_b_q.lo <= wdata;
                default:    ;
            endcase
        end
    end

    assign cfg_a = cfg_a_q;
    assign cfg_b = cfg_b_q;
    assign style = style_q;

    a_r2_enable_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADR_EN_A) |=> (cfg_a.en == $past(wdata)));

    a_r2_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == ADR_STAT_A || addr == ADR_STAT_B)) |=>
            (cfg_a == $past(cfg_a) && cfg_b == $past(cfg_b) && style == $past(style)));
endmodule

// File: rtl/isc_event_bank.sv
module isc_event_bank
    import isc_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ev,
    input  bank_cfg_t     cfg,
    input  logic          rd_clr,
    output logic [DW-1:0] status,
    output logic          req
);
    logic [DW-1:0] prev_q, status_q, status_d;
    logic [DW-1:0] lvl_sel, edge_sel, set_vec;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            trig_e t;
            assign t           = trig_of(cfg.hi[i], cfg.lo[i]);
            assign lvl_sel[i]  = trig_is_level(t);
            assign edge_sel[i] = ~trig_is_level(t);
            always_comb begin
                unique case (t)
                    TRIG_RISE: set_vec[i] = ev[i] & ~prev_q[i];
                    TRIG_FALL: set_vec[i] = ~ev[i] & prev_q[i];
                    default:   set_vec[i] = 1'b0;
                endcase
            end
        end else begin : g_absent
            assign lvl_sel[i]  = 1'b0;
            assign edge_sel[i] = 1'b0;
            assign set_vec[i]  = 1'b0;
        end
    end

    always_comb begin
        status_d = (lvl_sel & ev)
                 | (edge_sel & ((status_q & ~{DW{rd_clr}}) | set_vec));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= ev;
            status_q <= status_d;
        end
    end

    assign status = status_q;
    assign req    = |(status_q & cfg.en);

    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> (($past(status_q) & $past(edge_sel) & ~status_q) == '0));

    a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> ((status_q & $past(edge_sel) & ~$past(set_vec)) == '0));

    a_r5_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(lvl_sel)) == ($past(ev) & $past(lvl_sel))));

    a_r12_absent_bits_quiet: assert property (@(posedge clk) disable iff (rst)
        (status & ~IMPL) == '0);
endmodule

// File: rtl/isc_pin_drive.sv
module isc_pin_drive
    import isc_pkg::*;
(
    input  logic req,
    input  pin_e style,
    output logic level,
    output logic drive
);
    pin_out_t p;
    always_comb p = shape_pin(style, req);
    assign level = p.level;
    assign drive = p.drive;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [7:0]    ev_a,
    input  logic [7:0]    ev_b,
    output logic          irq_level,
    output logic          irq_drive
);
    bank_cfg_t     cfg_a, cfg_b;
    pin_e          style;
    logic [DW-1:0] stat_a, stat_b;
    logic          req_a, req_b, clr_a, clr_b;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    isc_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .style(style)
    );

    assign clr_a = reg_rd && (reg_addr == ADR_STAT_A);
    assign clr_b = reg_rd && (reg_addr == ADR_STAT_B);

    isc_event_bank #(.IMPL(IMPL_A)) u_bank_a (
        .clk(clk), .rst(rst), .ev(ev_a), .cfg(cfg_a), .rd_clr(clr_a),
        .status(stat_a), .req(req_a)
    );

    isc_event_bank #(.IMPL(IMPL_B)) u_bank_b (
        .clk(clk), .rst(rst), .ev(ev_b), .cfg(cfg_b), .rd_clr(clr_b),
        .status(stat_b), .req(req_b)
    );

    isc_pin_drive u_pin (
        .req(req_a | req_b), .style(style), .level(irq_level), .drive(irq_drive)
    );

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            ADR_PINCFG: rd_mux = {{(DW-2){1'b0}}, style};
            ADR_STAT_A: rd_mux = stat_a;
            ADR_STAT_B: rd_mux = stat_b;
            ADR_EN_A:   rd_mux = cfg_a.en;
            ADR_HI_A:   rd_mux = cfg_a.hi;
            ADR_LO_A:   rd_mux = cfg_a.lo;
            ADR_EN_B:   rd_mux = cfg_b.en;
            ADR_HI_B:   rd_mux = cfg_b.hi;
            ADR_LO_B:   rd_mux = cfg_b.lo;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end
    assign reg_rdata = rdata_q;

    // R8/R9: active-high pin mirrors the OR of enabled bits from both banks
    a_r9_active_high: assert property (@(posedge clk) disable iff (rst)
        (style == PIN_HIGH || style == PIN_RSVD) |->
            (irq_drive && irq_level == |((stat_a & cfg_a.en) | (stat_b & cfg_b.en))));

    a_r10_active_low: assert property (@(posedge clk) disable iff (rst)
        (style == PIN_LOW) |->
            (irq_drive && irq_level == !(|((stat_a & cfg_a.en) | (stat_b & cfg_b.en)))));

    a_r11_open_drain: assert property (@(posedge clk) disable iff (rst)
        (style == PIN_OD) |->
            (!irq_level && irq_drive == |((stat_a & cfg_a.en) | (stat_b & cfg_b.en))));
endmodule

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, ev_a, ev_b;
    logic       irq_level, irq_drive;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_a(ev_a), .ev_b(ev_b), .irq_level(irq_level), .irq_drive(irq_drive)
    );

    // Monitor: each sampled read is compared one half cycle later
    always begin
        @(posedge clk);
        if (reg_rd) begin
            @(negedge clk);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL unexpected read data: actual %02h expected none", reg_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_errors++;
                    $display("FAIL %s: read actual %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        tick();
    endtask

    task automatic rd_with_ev_a(input logic [3:0] a, input logic [7:0] e,
                                input logic [7:0] new_ev, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = a; ev_a = new_ev;
        tick();
        reg_rd = 1'b0;
        tick();
    endtask

    task automatic check_pin(input logic lvl, input logic drv, input string t);
        n_checks++;
        if (irq_level !== lvl || irq_drive !== drv) begin
            n_errors++;
            $display("FAIL %s: pin actual level=%b drive=%b expected level=%b drive=%b",
                     t, irq_level, irq_drive, lvl, drv);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        ev_a = '0; ev_b = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check_pin(1'b0, 1'b1, "R1 idle pin");
        rd(4'd1, 8'h00, "R1 status A clear");
        rd(4'd3, 8'h00, "R1 enable A clear");

        // R2 register access
        wr(4'd3, 8'hA5);
        rd(4'd3, 8'hA5, "R2 enable A readback");
        wr(4'd7, 8'h5A);
        rd(4'd7, 8'h5A, "R2 high B readback");
        wr(4'd7, 8'h00);
        wr(4'd3, 8'h00);
        wr(4'd1, 8'hFF);
        rd(4'd1, 8'h00, "R2 status write ignored");

        // R3 rising edge, sticky; R6 clear on read
        ev_a = 8'h01; tick();
        rd(4'd1, 8'h01, "R3 rising sets bit0");
        rd(4'd1, 8'h00, "R6 read cleared bit0");
        ev_a = 8'h00; tick();
        rd(4'd1, 8'h00, "R3 fall ignored in rising mode");

        // R4 falling edge on bit1
        wr(4'd5, 8'h02);
        ev_a = 8'h02; tick();
        rd(4'd1, 8'h00, "R4 rise ignored in falling mode");
        ev_a = 8'h00; tick();
        rd(4'd1, 8'h02, "R4 fall sets bit1");

        // R5 level on bit7 (10) and reserved on bit6 (11)
        wr(4'd4, 8'hC0);
        wr(4'd5, 8'h42);
        ev_a = 8'hC0; tick();
        rd(4'd1, 8'hC0, "R5 level bits follow");
        rd(4'd1, 8'hC0, "R5 level bits not cleared by read");
        ev_a = 8'h00; tick();
        rd(4'd1, 8'h00, "R5 level bits drop");

        // R12 unimplemented positions
        ev_a = 8'h38; ev_b = 8'hF1; tick();
        rd(4'd1, 8'h00, "R12 bank A absent bits");
        rd(4'd2, 8'h00, "R12 bank B absent bits");
        ev_a = 8'h00; ev_b = 8'h00; tick();

        // R7 masking, R9 active high
        ev_a = 8'h01; tick();
        check_pin(1'b0, 1'b1, "R7 disabled source blocked");
        rd(4'd1, 8'h01, "R7 disabled source still recorded");
        ev_a = 8'h00; tick();
        ev_a = 8'h01; tick();
        wr(4'd3, 8'h01);
        check_pin(1'b1, 1'b1, "R9 active high asserted");
        rd(4'd1, 8'h01, "R6 read returns pending bit");
        check_pin(1'b0, 1'b1, "R6 pin drops after read");

        // R10 active low, R8 bank B alone
        wr(4'd0, 8'h01);
        check_pin(1'b1, 1'b1, "R10 idle active low");
        wr(4'd6, 8'h08);
        ev_b = 8'h08; tick();
        check_pin(1'b0, 1'b1, "R8 bank B raises request, R10 low");

        // R11 open drain, reserved style
        wr(4'd0, 8'h02);
        check_pin(1'b0, 1'b1, "R11 open drain pulls low");
        rd(4'd2, 8'h08, "R8 bank B status");
        check_pin(1'b0, 1'b0, "R11 open drain released");
        wr(4'd0, 8'h03);
        rd(4'd0, 8'h03, "R2 pin style readback");
        check_pin(1'b0, 1'b1, "R9 reserved style acts active high");
        ev_b = 8'h00;

        // R6 edge on the same edge as the read survives
        wr(4'd0, 8'h00);
        ev_a = 8'h00; tick();
        rd_with_ev_a(4'd1, 8'h00, 8'h01, "R6 read with coincident edge");
        check_pin(1'b1, 1'b1, "R6 coincident edge kept");
        rd(4'd1, 8'h01, "R6 coincident edge readable");

        repeat (2) tick();
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule